// File: doc/BRIEF.md
# Serial Command Frame Parser

This block turns a stream of received bytes into register-bus accesses. It sits between a byte-level serial receiver and a small 32-bit register bus. It takes bytes through a valid/ready handshake and looks for delimited command frames. For each well-formed frame it issues exactly one bus read, one bus write or one core reset. It then sends a framed reply, one byte at a time, to a serial transmitter through a second valid/ready handshake.

A frame starts with 0x55 and ends with 0xAA. The byte after the start byte selects the command, and the command fixes how many argument bytes follow. A reset (0x01) takes no arguments. A read (0x10) takes a core address and then a register address. A write (0x11) takes a core address, a register address and then the data bytes, most significant byte first.

While a reply is outstanding, the parser refuses new input. Frames that are malformed or carry an unknown command produce an error reply and make no bus access.

Top module: `cmd_frame_parser`

## Requirements
- R1: In the idle state every accepted byte other than 0x55 is dropped and produces no reply, no bus access and no reset. Accepting 0x55 makes the next accepted byte the command byte.
- R2: The frame 0x55 0x01 0xAA raises `core_rst` for exactly one clock cycle, with `bus_cs` low. It is answered with 0x55 0x7D 0x01 0xAA.
- R3: The frame 0x55 0x10 C R 0xAA gives one cycle with `bus_cs`=1, `bus_we`=0, `bus_core`=C and `bus_reg`=R. The reply is 0x55 0x7F C R, then the four bytes of `bus_rdata` as sampled in that cycle (bits 31:24 first), then 0xAA. The reply's first byte is offered in the cycle after the access.
- R4: The frame 0x55 0x11 C R D3 D2 D1 D0 0xAA gives one cycle with `bus_cs`=1, `bus_we`=1, `bus_core`=C, `bus_reg`=R and `bus_wdata`={D3,D2,D1,D0}. It is answered with 0x55 0x7E C R 0xAA. Bytes equal to 0x55 or 0xAA inside the arguments are treated as data.
- R5: If the byte in the end position of a known command is not 0xAA, there is no bus access and no reset pulse. The reply is 0x55 0xFE K 0xAA, where K is the command byte. That byte is consumed and the parser returns to idle.
- R6: A command byte other than 0x01, 0x10 or 0x11 is answered at once with 0x55 0xFE K 0xAA, with no bus access. The bytes that follow are parsed from the idle state.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value. A reply byte counts as sent only in a cycle where both are high.
- R8: `rx_ready` is low from the cycle after a frame's last byte is accepted until the last reply byte has been taken. It is never high together with `tx_valid`.
- R9: After reset, `rx_ready` is 1 and `tx_valid`, `bus_cs` and `core_rst` are 0.
- R10: `bus_cs` is high for exactly one cycle for each valid read or write frame and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Parser accepts a byte this cycle |
| tx_valid | output | 1 | Reply byte offered |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter takes the offered byte |
| core_rst | output | 1 | One-cycle reset pulse to the attached core |
| bus_cs | output | 1 | Bus chip select |
| bus_we | output | 1 | Bus write enable |
| bus_core | output | 8 | Core address |
| bus_reg | output | 8 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled in the select cycle |

## Verification
The bench first sends stray bytes and then clean frames of all three commands. This shows that idle filtering is separate from command decoding. A write followed by a read-back of a register shows that the byte order is the same in both directions. A write whose data contains 0x55 and 0xAA shows that the parser counts argument bytes instead of scanning for delimiters. Frames with a wrong end byte, and an unknown command followed by a stray 0xAA and a valid frame, show that error handling is separate from normal completion and that the parser recovers afterwards. The transmitter's ready is then stalled pseudo-randomly, which shows that reply sequencing and input blocking depend on the handshake and not on fixed timing.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam logic [7:0] FRM_OPEN  = 8'h55;
    localparam logic [7:0] FRM_CLOSE = 8'hAA;

    localparam logic [7:0] OP_RESET = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h10;
    localparam logic [7:0] OP_WRITE = 8'h11;

    localparam logic [7:0] REPLY_READ  = 8'h7F;
    localparam logic [7:0] REPLY_WRITE = 8'h7E;
    localparam logic [7:0] REPLY_RESET = 8'h7D;
    localparam logic [7:0] REPLY_ERROR = 8'hFE;

    typedef enum logic [1:0] {
        RK_READ,
        RK_WRITE,
        RK_RESET,
        RK_ERROR
    } reply_kind_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_OPCODE,
        PS_ARGS,
        PS_CLOSE,
        PS_EXEC,
        PS_DRAIN
    } parse_state_e;

endpackage

// File: rtl/cmdp_frame_rx.sv
module cmdp_frame_rx
    import cmdp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic              reply_busy,
    output logic              exec,
    output logic              frame_ok,
    output logic [7:0]        opcode,
    output logic [7:0]        core_addr,
    output logic [7:0]        reg_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int NBYTES = DATA_W / 8;
    localparam int ARG_B  = NBYTES + 2;
    localparam int ARG_W  = ARG_B * 8;
    localparam int CNT_W  = $clog2(ARG_B + 1);

    typedef struct packed {
        parse_state_e       st;
        logic [7:0]         op;
        logic               ok;
        logic [CNT_W-1:0]   left;
        logic [ARG_W-1:0]   args;
    } rx_regs_t;

    rx_regs_t q, d;
    logic     take;

    always_comb begin
        d        = q;
        rx_ready = (q.st == PS_IDLE) || (q.st == PS_OPCODE) ||
                   (q.st == PS_ARGS) || (q.st == PS_CLOSE);
        take     = rx_valid && rx_ready;
        case (q.st)
            PS_IDLE: begin
                if (take && rx_data == FRM_OPEN) d.st = PS_OPCODE;
            end
            PS_OPCODE: begin
                if (take) begin
                    d.op = rx_data;
                    d.ok = 1'b0;
                    case (rx_data)
                        OP_RESET: begin
                            d.left = '0;
                            d.st   = PS_CLOSE;
                        end
                        OP_READ: begin
                            d.left = CNT_W'(2);
                            d.st   = PS_ARGS;
                        end
                        OP_WRITE: begin
                            d.left = CNT_W'(ARG_B);
                            d.st   = PS_ARGS;
                        end
                        default: d.st = PS_EXEC;
                    endcase
                end
            end
            PS_ARGS: begin
                if (take) begin
                    d.args = {q.args[ARG_W-9:0], rx_data};
                    d.left = q.left - CNT_W'(1);
                    if (q.left == CNT_W'(1)) d.st = PS_CLOSE;
                end
            end
            PS_CLOSE: begin
                if (take) begin
                    d.ok = (rx_data == FRM_CLOSE);
                    d.st = PS_EXEC;
                end
            end
            PS_EXEC: d.st = PS_DRAIN;
            PS_DRAIN: begin
                if (!reply_busy) d.st = PS_IDLE;
            end
            default: d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        exec     = (q.st == PS_EXEC);
        frame_ok = q.ok;
        opcode   = q.op;
        wr_data  = q.args[DATA_W-1:0];
        if (q.op == OP_WRITE) begin
            core_addr = q.args[ARG_W-1 -: 8];
            reg_addr  = q.args[ARG_W-9 -: 8];
        end else begin
            core_addr = q.args[15:8];
            reg_addr  = q.args[7:0];
        end
    end

endmodule

// File: rtl/cmdp_reply_tx.sv
module cmdp_reply_tx
    import cmdp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  reply_kind_e       kind,
    input  logic [7:0]        opcode,
    input  logic [7:0]        core_addr,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              busy
);

    localparam int NBYTES = DATA_W / 8;
    localparam int RSP_B  = NBYTES + 5;
    localparam int RSP_W  = RSP_B * 8;
    localparam int IDX_W  = $clog2(RSP_B + 1);

    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   left;
        logic [RSP_W-1:0]   frame;
    } tx_regs_t;

    tx_regs_t           q, d;
    logic [RSP_W-1:0]   load_frame;
    logic [IDX_W-1:0]   load_len;

    always_comb begin
        case (kind)
            RK_READ: begin
                load_frame = {FRM_OPEN, REPLY_READ, core_addr, reg_addr, rd_data, FRM_CLOSE};
                load_len   = IDX_W'(RSP_B);
            end
            RK_WRITE: begin
                load_frame = {FRM_OPEN, REPLY_WRITE, core_addr, reg_addr, FRM_CLOSE,
                              {DATA_W{1'b0}}};
                load_len   = IDX_W'(5);
            end
            RK_RESET: begin
                load_frame = {FRM_OPEN, REPLY_RESET, opcode, FRM_CLOSE, {(DATA_W + 8){1'b0}}};
                load_len   = IDX_W'(4);
            end
            default: begin
                load_frame = {FRM_OPEN, REPLY_ERROR, opcode, FRM_CLOSE, {(DATA_W + 8){1'b0}}};
                load_len   = IDX_W'(4);
            end
        endcase
    end

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.left  = load_len;
                d.frame = load_frame;
            end
        end else if (tx_ready) begin
            d.frame = {q.frame[RSP_W-9:0], 8'h00};
            d.left  = q.left - IDX_W'(1);
            if (q.left == IDX_W'(1)) d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_valid = q.busy;
    assign tx_data  = q.frame[RSP_W-1 -: 8];
    assign busy     = q.busy;

endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
    import cmdp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              core_rst,
    output logic              bus_cs,
    output logic              bus_we,
    output logic [7:0]        bus_core,
    output logic [7:0]        bus_reg,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic        exec, frame_ok, reply_busy;
    logic [7:0]  opcode;
    reply_kind_e kind;

    cmdp_frame_rx #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .reply_busy (reply_busy),
        .exec       (exec),
        .frame_ok   (frame_ok),
        .opcode     (opcode),
        .core_addr  (bus_core),
        .reg_addr   (bus_reg),
        .wr_data    (bus_wdata)
    );

    always_comb begin
        if (!frame_ok) kind = RK_ERROR;
        else begin
            case (opcode)
                OP_READ:  kind = RK_READ;
                OP_WRITE: kind = RK_WRITE;
                default:  kind = RK_RESET;
            endcase
        end
        bus_cs   = exec && frame_ok && (opcode == OP_READ || opcode == OP_WRITE);
        bus_we   = exec && frame_ok && (opcode == OP_WRITE);
        core_rst = exec && frame_ok && (opcode == OP_RESET);
    end

    cmdp_reply_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (exec),
        .kind      (kind),
        .opcode    (opcode),
        .core_addr (bus_core),
        .reg_addr  (bus_reg),
        .rd_data   (bus_rdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .busy      (reply_busy)
    );

endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready,
    input logic       core_rst,
    input logic       bus_cs
);

    AST_CS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |=> !bus_cs);  // R10

    AST_RST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !core_rst);  // R2

    AST_RST_WITHOUT_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> !bus_cs);  // R2

    AST_REPLY_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |=> (tx_valid && tx_data == 8'h55));  // R3

    AST_INPUT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);  // R8

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));  // R7

endmodule

bind cmd_frame_parser cmdp_checker u_cmdp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .core_rst (core_rst),
    .bus_cs   (bus_cs)
);

// File: tb/cmd_frame_parser_bench.sv
`timescale 1ns/1ps
module cmd_frame_parser_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        core_rst;
    logic        bus_cs;
    logic        bus_we;
    logic [7:0]  bus_core;
    logic [7:0]  bus_reg;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    logic [31:0] shadow = 32'h0BAD_F00D;
    assign bus_rdata = shadow ^ {bus_core, bus_reg, ~bus_core, ~bus_reg};

    always #4 clk = ~clk;

    cmd_frame_parser u_cmd_frame_parser (.*);

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    bit    stall_en = 1'b0;
    bit    mon_en   = 1'b0;

    // expected event queues
    logic [48:0] exp_bus[$];
    logic [7:0]  exp_tx[$];
    string       exp_tag[$];
    int          exp_rst = 0;

    // reference parser state
    int          m_st = 0;
    logic [7:0]  m_op;
    logic [7:0]  m_args[$];
    int          m_need = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_reply(input string tag, input logic [7:0] b);
        exp_tx.push_back(b);
        exp_tag.push_back(tag);
    endtask

    task automatic push_err(input string tag, input logic [7:0] op);
        push_reply(tag, 8'h55); push_reply(tag, 8'hFE);
        push_reply(tag, op);    push_reply(tag, 8'hAA);
    endtask

    task automatic model_byte(input logic [7:0] b);
        logic [31:0] rd, wd;
        case (m_st)
            0: if (b == 8'h55) m_st = 1;
            1: begin
                m_op = b;
                m_args.delete();
                if (b == 8'h01) begin m_need = 0; m_st = 3; end
                else if (b == 8'h10) begin m_need = 2; m_st = 2; end
                else if (b == 8'h11) begin m_need = 6; m_st = 2; end
                else begin push_err("R6", b); m_st = 0; end
            end
            2: begin
                m_args.push_back(b);
                if (m_args.size() == m_need) m_st = 3;
            end
            default: begin
                m_st = 0;
                if (b != 8'hAA) push_err("R5", m_op);
                else if (m_op == 8'h01) begin
                    exp_rst++;
                    push_reply("R2", 8'h55); push_reply("R2", 8'h7D);
                    push_reply("R2", 8'h01); push_reply("R2", 8'hAA);
                end else if (m_op == 8'h10) begin
                    rd = shadow ^ {m_args[0], m_args[1], ~m_args[0], ~m_args[1]};
                    exp_bus.push_back({1'b0, m_args[0], m_args[1], 32'h0});
                    push_reply("R3", 8'h55); push_reply("R3", 8'h7F);
                    push_reply("R3", m_args[0]); push_reply("R3", m_args[1]);
                    for (int i = 3; i >= 0; i--) push_reply("R3", rd[i*8 +: 8]);
                    push_reply("R3", 8'hAA);
                end else begin
                    wd = {m_args[2], m_args[3], m_args[4], m_args[5]};
                    exp_bus.push_back({1'b1, m_args[0], m_args[1], wd});
                    push_reply("R4", 8'h55); push_reply("R4", 8'h7E);
                    push_reply("R4", m_args[0]); push_reply("R4", m_args[1]);
                    push_reply("R4", 8'hAA);
                end
            end
        endcase
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        rx_valid = 1'b1;
        rx_data  = b;
        forever begin
            @(negedge clk);
            if (rx_ready) break;
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
        model_byte(b);
    endtask

    task automatic send_frame(input logic [7:0] bytes[$]);
        foreach (bytes[i]) send_byte(bytes[i]);
    endtask

    // transmitter ready pattern
    initial begin
        logic [7:0] lfsr = 8'hA5;
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tx_ready = stall_en ? lfsr[0] : 1'b1;
        end
    end

    // per-clock comparison against the reference
    initial begin
        bit         prev_stall = 1'b0;
        bit         prev_rst   = 1'b0;
        logic [7:0] prev_data  = 8'h00;
        logic [48:0] e;
        logic [48:0] a;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (exp_tx.size() != 0 || tx_valid)
                    chk(!rx_ready, "R8", "rx_ready during reply", rx_ready, 0);
                if (prev_stall)
                    chk(tx_valid && tx_data == prev_data, "R7", "held byte",
                        {tx_valid, tx_data}, {1'b1, prev_data});
                prev_stall = tx_valid && !tx_ready;
                prev_data  = tx_data;
                if (bus_cs) begin
                    if (exp_bus.size() == 0)
                        chk(0, "R10", "unexpected bus_cs", 1, 0);
                    else begin
                        e = exp_bus.pop_front();
                        a = {bus_we, bus_core, bus_reg, bus_we ? bus_wdata : 32'h0};
                        chk(a == e, e[48] ? "R4" : "R3", "bus access", a, e);
                        if (bus_we) shadow = bus_wdata;
                    end
                end
                if (core_rst) begin
                    chk(exp_rst != 0, "R2", "unexpected core_rst", 1, 0);
                    chk(!prev_rst, "R2", "core_rst longer than one cycle", 1, 0);
                    if (exp_rst != 0) exp_rst--;
                end
                prev_rst = core_rst;
                if (tx_valid && tx_ready) begin
                    if (exp_tx.size() == 0)
                        chk(0, "R1", "unexpected reply byte", tx_data, 0);
                    else
                        chk(tx_data == exp_tx[0], exp_tag[0], "reply byte",
                            tx_data, exp_tx[0]);
                    if (exp_tx.size() != 0) begin
                        void'(exp_tx.pop_front());
                        void'(exp_tag.pop_front());
                    end
                end
            end
        end
    end

    task automatic drain();
        while (exp_tx.size() != 0) @(posedge clk);
        repeat (6) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(rx_ready == 1'b1, "R9", "rx_ready after reset", rx_ready, 1);
        chk(tx_valid == 1'b0, "R9", "tx_valid after reset", tx_valid, 0);
        chk(bus_cs == 1'b0, "R9", "bus_cs after reset", bus_cs, 0);
        chk(core_rst == 1'b0, "R9", "core_rst after reset", core_rst, 0);
        mon_en = 1'b1;

        // R1: stray bytes dropped, then R2 reset frame
        send_frame('{8'h00, 8'hAA, 8'h12, 8'h7F});
        send_frame('{8'h55, 8'h01, 8'hAA});
        drain();
        // R3 read, R4 write and read-back
        send_frame('{8'h55, 8'h10, 8'h03, 8'h21, 8'hAA});
        send_frame('{8'h55, 8'h11, 8'h03, 8'h21, 8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'hAA});
        send_frame('{8'h55, 8'h10, 8'h03, 8'h21, 8'hAA});
        // R4: delimiter values as data
        send_frame('{8'h55, 8'h11, 8'h55, 8'hAA, 8'h55, 8'hAA, 8'h55, 8'hAA, 8'hAA});
        send_frame('{8'h55, 8'h10, 8'h55, 8'hAA, 8'hAA});
        drain();
        // R5: wrong end byte
        send_frame('{8'h55, 8'h11, 8'h01, 8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55});
        send_frame('{8'h55, 8'h10, 8'h01, 8'h02, 8'h00});
        send_frame('{8'h55, 8'h01, 8'h55});
        // R6: unknown command, trailing byte from idle, recovery
        send_frame('{8'h55, 8'h42, 8'hAA, 8'h55, 8'h01, 8'hAA});
        drain();
        // R7 / R8 with a stalling transmitter
        stall_en = 1'b1;
        send_frame('{8'h55, 8'h10, 8'h07, 8'h44, 8'hAA});
        send_frame('{8'h55, 8'h11, 8'h07, 8'h44, 8'h01, 8'h23, 8'h45, 8'h67, 8'hAA});
        send_frame('{8'h55, 8'h10, 8'h07, 8'h44, 8'hAA});
        send_frame('{8'h55, 8'h01, 8'hAA});
        send_frame('{8'h55, 8'h99});
        drain();
        stall_en = 1'b0;
        repeat (4) @(negedge clk);

        chk(exp_bus.size() == 0, "R10", "missing bus accesses", exp_bus.size(), 0);
        chk(exp_rst == 0, "R2", "missing reset pulses", exp_rst, 0);
        chk(tx_valid == 1'b0, "R8", "idle after replies", tx_valid, 0);
        chk(rx_ready == 1'b1, "R8", "input open after replies", rx_ready, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule